// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a single-clock static RAM for a cache or local buffer. Every input (address, strobes, advance, chip enable, lane write enables and write data) is taken on the rising clock edge. The read word is held in a register and comes out on the next clock. The word is divided into equal byte-style lanes, and each lane has its own active-low write enable.

Two active-low address strobes open a burst.

- The processor-side strobe has priority and always causes a read. A write that it starts takes a second cycle, in which both strobes are high and the lane enables carry the write.
- The controller-side strobe causes a read or a write, depending on the lane enables.

Once a burst is open, an active-low advance input steps the low address bits through a wrapping four-beat sequence. Holding advance high inserts a wait state.

Top module: `burst_sram`

## Requirements
- R1: While reset is applied, and in the cycle after it, `dq_drive_o` is low and `dq_o` is all zeros.
- R2: A cycle with `strobe_cpu_n` low loads `addr_i` as the burst base and performs a read, even if `lane_we_n` has active bits. The word read is on `dq_o` after that edge.
- R3: A write can be deferred after a processor-strobe load. In the next cycle, with both strobes high and `adv_n` high, active lane enables write `wdata_i` to the loaded address.
- R4: A cycle with `strobe_cpu_n` high and `strobe_ctl_n` low loads `addr_i`. If any bit of `lane_we_n` is 0, it writes; otherwise it reads.
- R5: When both strobes are low, the processor strobe wins: a read is done and nothing is written.
- R6: Within a burst, `adv_n` low increments address bits 1:0 modulo 4 before that cycle's access. The upper address bits stay fixed, so 3 is followed by 0 within the same row.
- R7: Within a burst, `adv_n` high keeps the same address, which gives a wait state.
- R8: After three increments, the next advance returns to the loaded low bits. Further advances then hold that address until a new strobe.
- R9: Bit 0 of `lane_we_n` controls data bits 8:0 and bit 1 controls bits 17:9. A lane whose enable is 1 keeps its stored value during a write.
- R10: `dq_drive_o` is high only while `oe_n` is low and the captured chip enable is active. When it is low, `dq_o` is all zeros.
- R11: `ce_n` is sampled only on strobe cycles. A burst loaded with `ce_n` high performs no read and no write, and does not drive the outputs, until a new strobe loads with `ce_n` low.
- R12: A strobe during an open burst abandons it. Later advances count from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low, forces read |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low, sampled on strobe cycles |
| oe_n | input | 1 | Output enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Registered read data, zero when not driven |
| dq_drive_o | output | 1 | High when `dq_o` would be driven onto the bus |

## Verification
Each array access takes effect on the same rising edge that samples its strobe or advance. The word it reads is on `dq_o` right after that edge. The bench therefore drives each vector on the falling edge and compares one time unit after the next rising edge. `dq_drive_o` also follows `oe_n` combinationally, so the output-enable checks toggle `oe_n` between edges and compare before the next rising edge. Writes have no direct output, so each write is followed by a later read cycle whose result is compared after its own edge.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   // Kind of array access decided for the current cycle
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

endpackage

// File: rtl/burst_addr_ctr.sv
// Wrapping burst counter over the low address bits.
// It counts linearly from the loaded value and parks once it returns to it.
module burst_addr_ctr #(
   parameter int unsigned BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [BURST_W-1:0] base_lo,
   output logic [BURST_W-1:0] eff_lo,
   output logic [BURST_W-1:0] cnt_q,
   output logic               wrap_q
);

   logic [BURST_W-1:0] start_q;
   logic [BURST_W-1:0] inc;
   logic               hit;

   assign inc = cnt_q + 1'b1;
   assign hit = step && !wrap_q && (inc == start_q);

   always_comb begin
      if (load)
         eff_lo = base_lo;
      else if (step && !wrap_q)
         eff_lo = inc;
      else
         eff_lo = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         start_q <= '0;
         wrap_q  <= 1'b0;
      end else begin
         cnt_q <= eff_lo;
         if (load) begin
            start_q <= base_lo;
            wrap_q  <= 1'b0;
         end else if (hit) begin
            wrap_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/sram_lane.sv
// One lane of the storage array, with a registered read port.
module sram_lane #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata_q
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en)
         rdata_q <= mem[addr];
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned LANE_W  = 9,
   parameter int unsigned LANES   = 2,
   parameter int unsigned BURST_W = 2,
   localparam int unsigned WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] dq_o,
   output logic              dq_drive_o
);

   localparam int unsigned HI_W = ADDR_W - BURST_W;

   // Elaboration-time parameter checks
   if (ADDR_W <= BURST_W) begin : g_bad_addr_w
      $error("burst_sram: ADDR_W must exceed BURST_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("burst_sram: LANES and LANE_W must be at least 1");
   end

   logic              load_cpu;
   logic              load_ctl;
   logic              load;
   logic              step;
   logic              ce_q;
   logic              ce_eff;
   logic              wr_any;
   logic [HI_W-1:0]   hi_q;
   logic [HI_W-1:0]   hi_eff;
   logic [BURST_W-1:0] eff_lo;
   logic [BURST_W-1:0] burst_lo_q;
   logic              wrap_q;
   logic [ADDR_W-1:0] eff_addr;
   logic [LANES-1:0]  lane_wr;
   logic [WORD_W-1:0] rd_word;
   acc_e              acc;

   // Strobe priority: the processor strobe wins over the controller strobe
   assign load_cpu = !strobe_cpu_n;
   assign load_ctl = strobe_cpu_n && !strobe_ctl_n;
   assign load     = load_cpu || load_ctl;
   assign step     = !load && !adv_n;

   assign ce_eff = load ? !ce_n : ce_q;
   assign wr_any = |(~lane_we_n);

   always_comb begin
      acc = ACC_NONE;
      if (ce_eff) begin
         if (!load_cpu && wr_any)
            acc = ACC_WRITE;
         else
            acc = ACC_READ;
      end
   end

   burst_addr_ctr #(.BURST_W(BURST_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .base_lo (addr_i[BURST_W-1:0]),
      .eff_lo  (eff_lo),
      .cnt_q   (burst_lo_q),
      .wrap_q  (wrap_q)
   );

   assign hi_eff   = load ? addr_i[ADDR_W-1:BURST_W] : hi_q;
   assign eff_addr = {hi_eff, eff_lo};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         ce_q <= 1'b0;
      end else if (load) begin
         hi_q <= addr_i[ADDR_W-1:BURST_W];
         ce_q <= !ce_n;
      end
   end

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_wr[gi] = (acc == ACC_WRITE) && !lane_we_n[gi];

      sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (lane_wr[gi]),
         .rd_en   (acc == ACC_READ),
         .addr    (eff_addr),
         .wdata   (wdata_i[gi*LANE_W +: LANE_W]),
         .rdata_q (rd_word[gi*LANE_W +: LANE_W])
      );
   end

   assign dq_drive_o = !oe_n && ce_q;
   assign dq_o       = dq_drive_o ? rd_word : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned LANES   = 2,
   parameter int unsigned BURST_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr_i,
   input logic               strobe_cpu_n,
   input logic               strobe_ctl_n,
   input logic               adv_n,
   input logic               oe_n,
   input logic               dq_drive_o,
   input logic               ce_q,
   input logic [BURST_W-1:0] burst_lo,
   input logic               wrapped,
   input logic [LANES-1:0]   lane_wr
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !dq_drive_o);

   assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_cpu_n |=> burst_lo == $past(addr_i[BURST_W-1:0]));

   assert_cpu_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_cpu_n |-> lane_wr == '0);

   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu_n && strobe_ctl_n && !adv_n && !wrapped)
         |=> burst_lo == BURST_W'($past(burst_lo) + 1'b1));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu_n && strobe_ctl_n && adv_n) |=> $stable(burst_lo));

   assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu_n && strobe_ctl_n && wrapped) |=> $stable(burst_lo));

   assert_drive_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive_o |-> !oe_n);

   assert_ce_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu_n && strobe_ctl_n) |=> $stable(ce_q));

   assert_dead_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_q && strobe_cpu_n && strobe_ctl_n) |-> lane_wr == '0);

   assert_ctl_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu_n && !strobe_ctl_n) |=> burst_lo == $past(addr_i[BURST_W-1:0]));

endmodule

bind burst_sram burst_sram_chk #(
   .ADDR_W  (ADDR_W),
   .LANES   (LANES),
   .BURST_W (BURST_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr_i       (addr_i),
   .strobe_cpu_n (strobe_cpu_n),
   .strobe_ctl_n (strobe_ctl_n),
   .adv_n        (adv_n),
   .oe_n         (oe_n),
   .dq_drive_o   (dq_drive_o),
   .ce_q         (ce_q),
   .burst_lo     (burst_lo_q),
   .wrapped      (wrap_q),
   .lane_wr      (lane_wr)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;

   localparam int unsigned AW = 8;
   localparam int unsigned WW = 18;
   localparam int unsigned NV = 30;

   typedef struct packed {
      logic          cpu;
      logic          ctl;
      logic          adv;
      logic          ce;
      logic          oe;
      logic [1:0]    ln;
      logic [AW-1:0] a;
      logic [WW-1:0] wd;
      logic          drv;
      logic [WW-1:0] ex;
      logic [3:0]    req;
   } vec_t;

   function automatic vec_t mk(logic cpu, logic ctl, logic adv, logic ce, logic oe,
                               logic [1:0] ln, logic [AW-1:0] a, logic [WW-1:0] wd,
                               logic drv, logic [WW-1:0] ex, logic [3:0] req);
      vec_t v;
      v.cpu = cpu; v.ctl = ctl; v.adv = adv; v.ce = ce; v.oe = oe;
      v.ln = ln; v.a = a; v.wd = wd; v.drv = drv; v.ex = ex; v.req = req;
      return v;
   endfunction

   localparam logic [WW-1:0] DA0  = 18'h12345;
   localparam logic [WW-1:0] DA1  = 18'h2ABCD;
   localparam logic [WW-1:0] DA2  = 18'h0F0F0;
   localparam logic [WW-1:0] DA3  = 18'h3C3C3;
   localparam logic [WW-1:0] DB   = 18'h15555;
   localparam logic [WW-1:0] DC   = 18'h2AAAA;
   localparam logic [WW-1:0] DD   = 18'h3FFFF;
   localparam logic [WW-1:0] DE   = 18'h00000;
   localparam logic [WW-1:0] DF   = 18'h11111;
   localparam logic [WW-1:0] MIX1 = {DB[17:9], DC[8:0]};
   localparam logic [WW-1:0] MIX2 = {DD[17:9], DC[8:0]};

   // Field order: cpu ctl adv ce oe lanes addr wdata | expected drive, expected data, requirement
   localparam vec_t TBL [NV] = '{
      mk(1,0,1,0,1,2'b00,8'h12,DA0,0,0,4),     // R4 controller write at 0x12
      mk(1,1,0,0,1,2'b00,8'h00,DA1,0,0,6),     // R6 write 0x13
      mk(1,1,0,0,1,2'b00,8'h00,DA2,0,0,6),     // R6 write 0x10, row fixed
      mk(1,1,0,0,1,2'b00,8'h00,DA3,0,0,6),     // R6 write 0x11
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA0,8),     // R8 wrap back to 0x12
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA0,8),     // R8 parked
      mk(0,1,1,0,0,2'b00,8'h13,DF,1,DA1,2),    // R2 processor read ignores lanes
      mk(1,1,1,0,0,2'b11,8'h00,0,1,DA1,7),     // R7 wait state, no write happened
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA2,6),     // R6
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA3,6),     // R6
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA0,6),     // R6
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA1,8),     // R8 wrap to start 0x13
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA1,8),     // R8 parked
      mk(0,1,1,0,1,2'b11,8'h40,0,0,0,3),       // R3 processor load
      mk(1,1,1,0,1,2'b00,8'h00,DB,0,0,3),      // R3 deferred write
      mk(1,0,1,0,0,2'b11,8'h40,0,1,DB,3),      // R3 read back
      mk(1,0,1,0,1,2'b10,8'h40,DC,0,0,9),      // R9 lower lane only
      mk(1,0,1,0,0,2'b11,8'h40,0,1,MIX1,9),    // R9
      mk(1,0,1,0,1,2'b01,8'h40,DD,0,0,9),      // R9 upper lane only
      mk(1,0,1,0,0,2'b11,8'h40,0,1,MIX2,9),    // R9
      mk(0,0,1,0,0,2'b00,8'h40,DE,1,MIX2,5),   // R5 both strobes: read
      mk(1,1,1,0,0,2'b11,8'h00,0,1,MIX2,5),    // R5 nothing written
      mk(1,0,1,1,0,2'b00,8'h40,DF,0,0,11),     // R11 deselected load
      mk(1,1,1,0,0,2'b00,8'h00,DF,0,0,11),     // R11 ce ignored, no write
      mk(1,0,1,0,0,2'b11,8'h40,0,1,MIX2,11),   // R11 contents unchanged
      mk(1,1,1,0,1,2'b11,8'h00,0,0,0,10),      // R10 oe high
      mk(1,0,1,0,0,2'b11,8'h12,0,1,DA0,4),     // R4 controller read
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA1,6),     // R6
      mk(1,0,1,0,0,2'b11,8'h10,0,1,DA2,12),    // R12 abandon burst
      mk(1,1,0,0,0,2'b11,8'h00,0,1,DA3,12)     // R12 counts from new base
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_i;
   logic          strobe_cpu_n, strobe_ctl_n, adv_n, ce_n, oe_n;
   logic [1:0]    lane_we_n;
   logic [WW-1:0] wdata_i;
   logic [WW-1:0] dq_o;
   logic          dq_drive_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   burst_sram uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_i       (addr_i),
      .strobe_cpu_n (strobe_cpu_n),
      .strobe_ctl_n (strobe_ctl_n),
      .adv_n        (adv_n),
      .ce_n         (ce_n),
      .oe_n         (oe_n),
      .lane_we_n    (lane_we_n),
      .wdata_i      (wdata_i),
      .dq_o         (dq_o),
      .dq_drive_o   (dq_drive_o)
   );

   task automatic check(input string req, input logic drv_ex, input logic [WW-1:0] dq_ex);
      n_chk++;
      if (dq_drive_o !== drv_ex || (drv_ex && dq_o !== dq_ex) || (!drv_ex && dq_o !== '0)) begin
         n_fail++;
         $display("FAIL %s: drive=%0b dq=%h expected drive=%0b dq=%h",
                  req, dq_drive_o, dq_o, drv_ex, drv_ex ? dq_ex : '0);
      end
   endtask

   task automatic idle_inputs();
      strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
      ce_n = 1'b1; oe_n = 1'b0; lane_we_n = 2'b11;
      addr_i = '0; wdata_i = '0;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      repeat (3) @(posedge clk);
      #1 check("R1", 1'b0, '0);        // R1 reset state
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check("R1", 1'b0, '0);        // R1 after release, nothing loaded

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         strobe_cpu_n = TBL[i].cpu; strobe_ctl_n = TBL[i].ctl; adv_n = TBL[i].adv;
         ce_n = TBL[i].ce; oe_n = TBL[i].oe; lane_we_n = TBL[i].ln;
         addr_i = TBL[i].a; wdata_i = TBL[i].wd;
         @(posedge clk);
         #1 check($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].drv, TBL[i].ex);
      end

      // R10: output enable gates the drive between edges
      @(negedge clk);
      strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1; lane_we_n = 2'b11; oe_n = 1'b1;
      #1 check("R10 oe off", 1'b0, '0);
      oe_n = 1'b0;
      #1 check("R10 oe on", 1'b1, DA3);

      // R1: reset in the middle of a burst
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      #1 check("R1 mid-run", 1'b0, '0);
      @(negedge clk) rst_n = 1'b1;
      idle_inputs();
      @(posedge clk);
      #1 check("R1 after reset", 1'b0, '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule